// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire bus when a target device has been left pulling the data line low, for instance after a transfer was cut short part-way through a byte. A controller raises `start` for one clock. If the data line, seen through a two-flop synchronizer, is high at that moment, the bus is already free and the block reports `done` straight away. If the line is low, the block toggles the clock line to step the stuck device through its remaining bits. After each pulse it samples the data line. It stops pulsing when the line reads high or when the pulse limit is reached. It then forces a stop condition by overriding both lines directly.

Both lines are open-drain, so each output is a low-drive enable: 1 pulls the wire low and 0 lets it float high. The length of a half period is either a count of system clocks or the interval between pulses on an external tick input, chosen by a parameter. The default is 1500 clocks, which is 6 µs at 250 MHz. `busy` covers the whole sequence, and `done` and `fail` report the outcome.

Top module: `bus_unstick_seq`

## Requirements
- R1: While reset is held and right after it is released, `scl_drive_low`, `sda_drive_low`, `busy`, `done` and `fail` are all 0.
- R2: When `start` is accepted while the synchronized data level is high (the input has been stable for at least two clocks), `done` is 1 in the cycle after the triggering edge. `fail` is 0, `busy` stays 0 and neither line is driven.
- R3: A recovery pulse drives SCL low for one half period and then releases it for one half period. With the internal timer, one half period is HALF_CYCLES clocks. A sequence with P pulses keeps `busy` high for exactly (2P+2)·HALF_CYCLES cycles.
- R4: The data level is checked at the end of each released half period. Pulsing stops at the first check that reads high, so a device that lets go after K pulses (K ≤ MAX_PULSES) receives exactly K pulses.
- R5: No more than MAX_PULSES (default 9) pulses are issued. If the data level is still low at the check after the last pulse, `fail` is 1 in the same cycle as `done`. Otherwise `fail` is 0 with `done`.
- R6: The stop is forced in three steps. First both lines are driven low for one half period. Then SCL is released while SDA is still held low for one half period. Then both lines are released. SDA is never driven low at any other time.
- R7: `busy` is high from the cycle after an accepted trigger until the final release. `done` is a one-cycle pulse, raised at the same edge where `busy` falls. Both lines are undriven whenever `busy` is low.
- R8: `start` pulses that arrive while `busy` is high are ignored. The sequence length and the pulse count do not change.
- R9: With USE_EXT_TICK=1, half periods are measured in `ext_tick` pulses instead of clocks. The pulse, check and stop behaviour is otherwise unchanged.
- R10: An accepted trigger clears `fail`, so a clean run that follows a failed run reports `fail` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle trigger for a recovery attempt |
| sda_in | input | 1 | Raw level sensed on the data line |
| ext_tick | input | 1 | Half-period tick, used only when USE_EXT_TICK=1 |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Data line still low after the last pulse; valid with done |

## Verification
The main instance is built with HALF_CYCLES=5 and the default MAX_PULSES=9. The short half period lets every pulse count from zero up past the limit, including a device that never lets go, finish in a few hundred cycles. It still leaves room for the two-flop synchronizer delay before each data check. A second instance uses USE_EXT_TICK=1 with a tick every four clocks, so that the external timing path and its unknown first-tick phase are exercised. A bus model releases the data line after a programmed number of clock pulses, so the exact pulse counts, the busy lengths and the stop ordering can all be predicted.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_CLK_LO    = 3'd1,
    ST_CLK_HI    = 3'd2,
    ST_STOP_BOTH = 3'd3,
    ST_STOP_SDA  = 3'd4
  } ustate_e;

  // Continue pulsing only while the line is still held and the budget remains.
  function automatic logic keep_pulsing(input logic sda_high,
                                        input int unsigned issued,
                                        input int unsigned limit);
    return !sda_high && (issued < limit);
  endfunction

  // Width needed to hold values 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/unstick_halftimer.sv
module unstick_halftimer #(
  parameter int unsigned HALF_CYCLES  = 1500,
  parameter bit          USE_EXT_TICK = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_tick,
  output logic tick
);
  localparam int unsigned CW = unstick_pkg::cnt_width(HALF_CYCLES);

  generate
    if (USE_EXT_TICK) begin : g_ext
      assign tick = run && ext_tick;
    end else begin : g_int
      logic [CW-1:0] cnt;
      logic          unused_ext;
      assign unused_ext = ext_tick;
      assign tick = run && (cnt == CW'(HALF_CYCLES - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
  import unstick_pkg::*;
#(
  parameter int unsigned MAX_PULSES = 9,
  localparam int unsigned PW = cnt_width(MAX_PULSES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sda_high,
  input  logic          tick,
  output ustate_e       state,
  output logic [PW-1:0] pulse_cnt,
  output logic          done,
  output logic          fail
);
  logic stuck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pulse_cnt <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      stuck_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          fail      <= 1'b0;
          pulse_cnt <= '0;
          stuck_q   <= 1'b0;
          if (sda_high) done  <= 1'b1;
          else          state <= ST_CLK_LO;
        end
        ST_CLK_LO: if (tick) begin
          state     <= ST_CLK_HI;
          pulse_cnt <= pulse_cnt + 1'b1;
        end
        ST_CLK_HI: if (tick) begin
          if (keep_pulsing(sda_high, int'(pulse_cnt), MAX_PULSES)) begin
            state <= ST_CLK_LO;
          end else begin
            state   <= ST_STOP_BOTH;
            stuck_q <= !sda_high;
          end
        end
        ST_STOP_BOTH: if (tick) state <= ST_STOP_SDA;
        ST_STOP_SDA: if (tick) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          fail  <= stuck_q;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq
  import unstick_pkg::*;
#(
  parameter int unsigned HALF_CYCLES  = 1500,
  parameter int unsigned MAX_PULSES   = 9,
  parameter bit          USE_EXT_TICK = 1'b0,
  localparam int unsigned PW = cnt_width(MAX_PULSES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sda_in,
  input  logic ext_tick,
  output logic scl_drive_low,
  output logic sda_drive_low,
  output logic busy,
  output logic done,
  output logic fail
);
  ustate_e       state;
  logic [PW-1:0] pulse_cnt;
  logic          sda_sync;
  logic          half_tick;

  unstick_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_sync)
  );

  unstick_halftimer #(.HALF_CYCLES(HALF_CYCLES), .USE_EXT_TICK(USE_EXT_TICK)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .ext_tick(ext_tick), .tick(half_tick)
  );

  unstick_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .sda_high(sda_sync),
    .tick(half_tick), .state(state), .pulse_cnt(pulse_cnt),
    .done(done), .fail(fail)
  );

  assign busy          = (state != ST_IDLE);
  assign scl_drive_low = (state == ST_CLK_LO) || (state == ST_STOP_BOTH);
  assign sda_drive_low = (state == ST_STOP_BOTH) || (state == ST_STOP_SDA);
endmodule

// File: rtl/bus_unstick_chk.sv
module bus_unstick_chk
  import unstick_pkg::*;
#(
  parameter int unsigned MAX_PULSES = 9,
  localparam int unsigned PW = cnt_width(MAX_PULSES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          scl_drive_low,
  input logic          sda_drive_low,
  input logic          half_tick,
  input ustate_e       state,
  input logic [PW-1:0] pulse_cnt
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy && !done && !fail); // R1
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scl_drive_low && !sda_drive_low); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= PW'(MAX_PULSES)); // R5
  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done); // R5
  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> scl_drive_low); // R6
  AST_STOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> !scl_drive_low && $past(!scl_drive_low)); // R6
  AST_RETRIGGER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !half_tick |=> $stable(state) && $stable(pulse_cnt)); // R8
endmodule

bind bus_unstick_seq bus_unstick_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fail(fail), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
  .half_tick(half_tick), .state(state), .pulse_cnt(pulse_cnt)
);

// File: tb/bus_unstick_seq_test.sv
module stuck_target_model (
  input  logic       clk,
  input  logic       arm,
  input  int         hold,
  input  logic       start,
  input  logic       scl_low,
  input  logic       sda_low,
  input  logic       busy,
  input  logic       done,
  input  logic       fail,
  output logic       sda_line,
  output int         pulses,
  output int         busy_cyc,
  output int         done_cnt,
  output logic       fail_seen,
  output int         latency,
  output int         both_cyc,
  output int         sda_only_cyc,
  output int         order_err
);
  logic holding, prev_scl, prev_sda, counting;
  initial begin
    holding = 1'b0; prev_scl = 1'b0; prev_sda = 1'b0; counting = 1'b0;
    pulses = 0; busy_cyc = 0; done_cnt = 0; fail_seen = 1'b0;
    latency = 0; both_cyc = 0; sda_only_cyc = 0; order_err = 0;
  end
  assign sda_line = !sda_low && !holding;

  always @(posedge clk) begin
    if (arm) begin
      holding <= (hold != 0); pulses <= 0; busy_cyc <= 0; done_cnt <= 0;
      fail_seen <= 1'b0; latency <= 0; counting <= 1'b0;
      both_cyc <= 0; sda_only_cyc <= 0; order_err <= 0;
    end else begin
      if (prev_scl && !scl_low && !sda_low) begin
        pulses <= pulses + 1;
        if (pulses + 1 >= hold) holding <= 1'b0;
      end
      if (busy) busy_cyc <= busy_cyc + 1;
      if (done) begin done_cnt <= done_cnt + 1; fail_seen <= fail; end
      if (start && !counting && done_cnt == 0) counting <= 1'b1;
      if (counting && done_cnt == 0) latency <= latency + 1;
      if (sda_low && scl_low) both_cyc <= both_cyc + 1;
      if (sda_low && !scl_low) sda_only_cyc <= sda_only_cyc + 1;
      if (sda_low && !prev_sda && !scl_low) order_err <= order_err + 1;
      if (prev_sda && !sda_low && scl_low) order_err <= order_err + 1;
      if (sda_low && !busy) order_err <= order_err + 1;
    end
    prev_scl <= scl_low;
    prev_sda <= sda_low;
  end
endmodule

module bus_unstick_seq_test;
  localparam int HALF = 5;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst_n, start, start2, arm, arm2, ext_tick;
  int   hold, hold2;
  logic scl_l, sda_l, busy, done, fail, sda_line;
  logic scl_l2, sda_l2, busy2, done2, fail2, sda_line2;
  int   pulses, busy_cyc, done_cnt, latency, both_cyc, sda_only_cyc, order_err;
  logic fail_seen, fail_seen2;
  int   pulses2, busy_cyc2, done_cnt2, latency2, both_cyc2, sda_only_cyc2, order_err2;
  int   tests = 0, fails = 0;

  bus_unstick_seq #(.HALF_CYCLES(HALF), .MAX_PULSES(MAXP), .USE_EXT_TICK(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sda_in(sda_line), .ext_tick(1'b0),
    .scl_drive_low(scl_l), .sda_drive_low(sda_l), .busy(busy), .done(done), .fail(fail)
  );
  stuck_target_model m1 (
    .clk(clk), .arm(arm), .hold(hold), .start(start), .scl_low(scl_l), .sda_low(sda_l),
    .busy(busy), .done(done), .fail(fail), .sda_line(sda_line), .pulses(pulses),
    .busy_cyc(busy_cyc), .done_cnt(done_cnt), .fail_seen(fail_seen), .latency(latency),
    .both_cyc(both_cyc), .sda_only_cyc(sda_only_cyc), .order_err(order_err)
  );

  bus_unstick_seq #(.HALF_CYCLES(HALF), .MAX_PULSES(MAXP), .USE_EXT_TICK(1'b1)) uut_ext (
    .clk(clk), .rst_n(rst_n), .start(start2), .sda_in(sda_line2), .ext_tick(ext_tick),
    .scl_drive_low(scl_l2), .sda_drive_low(sda_l2), .busy(busy2), .done(done2), .fail(fail2)
  );
  stuck_target_model m2 (
    .clk(clk), .arm(arm2), .hold(hold2), .start(start2), .scl_low(scl_l2), .sda_low(sda_l2),
    .busy(busy2), .done(done2), .fail(fail2), .sda_line(sda_line2), .pulses(pulses2),
    .busy_cyc(busy_cyc2), .done_cnt(done_cnt2), .fail_seen(fail_seen2), .latency(latency2),
    .both_cyc(both_cyc2), .sda_only_cyc(sda_only_cyc2), .order_err(order_err2)
  );

  int tick_div = 0;
  always @(posedge clk) begin
    tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
    ext_tick <= (tick_div == 3);
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // hold, expected pulses, expected fail
  localparam int NV = 7;
  localparam int VEC [NV][3] = '{
    '{1, 1, 0}, '{3, 3, 0}, '{10, 9, 1}, '{0, 0, 0},
    '{9, 9, 0}, '{15, 9, 1}, '{4, 4, 0}
  };

  task automatic arm_model(input int h);
    @(negedge clk); hold = h; arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_done1();
    for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; start2 = 1'b0; arm = 1'b0; arm2 = 1'b0;
    hold = 0; hold2 = 0; ext_tick = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 scl idle", int'(scl_l), 0);
    check("R1 sda idle", int'(sda_l), 0);
    check("R1 busy/done/fail", int'({busy, done, fail}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'({scl_l, sda_l, busy, done, fail}), 0);

    for (int v = 0; v < NV; v++) begin
      automatic int h  = VEC[v][0];
      automatic int ep = VEC[v][1];
      automatic int ef = VEC[v][2];
      automatic int eb = (ep == 0) ? 0 : (2 * ep + 2) * HALF;
      arm_model(h);
      start = 1'b1; @(negedge clk); start = 1'b0;
      wait_done1();
      check($sformatf("R4/R5 pulses hold=%0d", h), pulses, ep);
      check($sformatf("R5/R10 fail hold=%0d", h), int'(fail_seen), ef);
      check($sformatf("R3 busy length hold=%0d", h), busy_cyc, eb);
      check($sformatf("R7 done once hold=%0d", h), done_cnt, 1);
      check($sformatf("R2/R7 done latency hold=%0d", h), latency, eb + 1);
      check($sformatf("R6 both-low half hold=%0d", h), both_cyc, (ep == 0) ? 0 : HALF);
      check($sformatf("R6 sda-only half hold=%0d", h), sda_only_cyc, (ep == 0) ? 0 : HALF);
      check($sformatf("R6 ordering hold=%0d", h), order_err, 0);
    end

    // R8: retriggers while busy change nothing
    arm_model(3);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (15) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done1();
    check("R8 pulses unchanged", pulses, 3);
    check("R8 busy length unchanged", busy_cyc, 8 * HALF);
    check("R8 single done", done_cnt, 1);

    // R2: idle outputs undriven after an immediate completion
    arm_model(0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check("R2 immediate done", int'(done), 1);
    check("R2 no drive", int'({scl_l, sda_l, busy}), 0);

    // R9: external tick variant
    @(negedge clk); hold2 = 2; arm2 = 1'b1;
    @(negedge clk); arm2 = 1'b0;
    repeat (4) @(negedge clk);
    start2 = 1'b1; @(negedge clk); start2 = 1'b0;
    for (int i = 0; i < 400 && done_cnt2 == 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R9 ext pulses", pulses2, 2);
    check("R9 ext fail", int'(fail_seen2), 0);
    check("R9 ext busy in range", int'(busy_cyc2 >= 21 && busy_cyc2 <= 24), 1);
    check("R9 ext both-low quarter", both_cyc2, 4);
    check("R9 ext ordering", order_err2, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule